// File: doc/BRIEF.md
# Wavefront Lane-Mask Control Unit

This block is the scalar control side of an 8-lane wavefront as it steps through an if/else region whose lanes disagree. It keeps two lane masks. The execute mask says which lanes are live. The condition mask holds the latest per-lane compare outcome. A small bank of scalar registers can hold a copy of the execute mask, so an outer mask can be put back after the region ends.

Divergence is handled only through explicit scalar operations on these masks. There is no hardware reconvergence stack. A typical sequence runs as follows:
- save the execute mask to a scalar register;
- AND the execute mask with the condition mask, then skip the if-body when the condition mask is all zero;
- invert the execute mask and AND it with the saved copy to form the else mask, then skip the else-body when nothing is live;
- restore the saved copy.

Each cycle the block takes one instruction, given as an opcode, a scalar register selector, a lane compare vector and a branch target. It reports the live mask, whether the last instruction branched, and the program counter of the next instruction.

Top module: `lane_mask_ctrl`

## Requirements
- R1: After reset the execute mask is all ones, the condition mask is zero (so a condition-zero branch issued first is taken), the PC is 0 and the taken flag is low.
- R2: Opcode 1 (compare) writes `lane_cmp` into the condition mask only in lanes whose execute bit is set. Lanes that are not live keep their old condition bit.
- R3: Opcode 2 (save) copies the execute mask into scalar register `sreg_sel`. Opcode 6 (restore) loads the execute mask from that register.
- R4: Opcode 3 sets the execute mask to the execute mask AND the condition mask.
- R5: Opcode 4 inverts every bit of the execute mask.
- R6: Opcode 5 sets the execute mask to the execute mask AND scalar register `sreg_sel`.
- R7: Opcode 7 branches to `br_target` exactly when all condition mask bits are zero.
- R8: Opcode 8 branches to `br_target` exactly when all execute mask bits are zero.
- R9: Every accepted instruction that does not branch, including a branch whose condition fails and an unused opcode (0 or 9 to 15), sets the PC to the old PC plus one. A taken branch sets the PC to `br_target`.
- R10: While `instr_valid` is low, no mask, PC or scalar register changes and the taken flag is low. Opcode 0 and opcodes 9 to 15 change no mask.
- R11: Every instruction updates its registers at the clock edge that accepts it. A branch in the very next cycle sees the new mask.
- R12: With an all-ones execute mask and a compare true in lanes 0, 2 and 5 (0x25), the else-path sequence gives an execute mask of 0xDA (lanes 1, 3, 4, 6 and 7).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| instr_valid | input | 1 | Instruction present this cycle |
| opcode | input | 4 | Operation code, encodings as in the requirements |
| sreg_sel | input | 2 | Scalar register selector |
| lane_cmp | input | 8 | Per-lane compare outcome |
| br_target | input | 16 | Branch destination |
| exec_mask | output | 8 | Current execute mask |
| br_taken | output | 1 | The last accepted instruction branched |
| pc_next | output | 16 | PC of the next instruction |

## Verification
Each result is due one clock after the instruction that causes it. The masks, the PC and the taken flag are all registered at the edge that accepts the instruction. The driver applies an instruction at a falling edge and pushes its expected outcome into a queue. The monitor pops one entry just after each following rising edge, so every comparison lands in the cycle the result first appears. Back-to-back sequences, such as a mask update followed at once by a branch on that mask, check that a branch sees a value written one cycle earlier.

// File: rtl/lmc_pkg.sv
package lmc_pkg;
  localparam int OP_W = 4;

  localparam logic [OP_W-1:0] OP_NOP      = 4'd0;
  localparam logic [OP_W-1:0] OP_VCMP     = 4'd1;
  localparam logic [OP_W-1:0] OP_SAVE     = 4'd2;
  localparam logic [OP_W-1:0] OP_AND_VCC  = 4'd3;
  localparam logic [OP_W-1:0] OP_INV      = 4'd4;
  localparam logic [OP_W-1:0] OP_AND_SREG = 4'd5;
  localparam logic [OP_W-1:0] OP_RESTORE  = 4'd6;
  localparam logic [OP_W-1:0] OP_BR_CZ    = 4'd7;
  localparam logic [OP_W-1:0] OP_BR_EZ    = 4'd8;

  typedef struct packed {
    logic vcmp;
    logic save;
    logic and_vcc;
    logic inv;
    logic and_sreg;
    logic restore;
    logic br_cz;
    logic br_ez;
    logic adv;
  } ctrl_t;
endpackage

// File: rtl/lmc_decode.sv
module lmc_decode
  import lmc_pkg::*;
(
  input  logic            valid_i,
  input  logic [OP_W-1:0] op_i,
  output ctrl_t           ctrl_o
);
  always_comb begin
    ctrl_o = '0;
    if (valid_i) begin
      ctrl_o.adv = 1'b1;
      case (op_i)
        OP_VCMP:     ctrl_o.vcmp     = 1'b1;
        OP_SAVE:     ctrl_o.save     = 1'b1;
        OP_AND_VCC:  ctrl_o.and_vcc  = 1'b1;
        OP_INV:      ctrl_o.inv      = 1'b1;
        OP_AND_SREG: ctrl_o.and_sreg = 1'b1;
        OP_RESTORE:  ctrl_o.restore  = 1'b1;
        OP_BR_CZ:    ctrl_o.br_cz    = 1'b1;
        OP_BR_EZ:    ctrl_o.br_ez    = 1'b1;
        default:     ;
      endcase
    end
  end
endmodule

// File: rtl/lmc_mask_regs.sv
module lmc_mask_regs
  import lmc_pkg::*;
#(
  parameter int LANES = 8,
  parameter int NSREG = 4,
  localparam int SEL_W = $clog2(NSREG)
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  ctrl_t            ctrl_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic [LANES-1:0] cmp_i,
  output logic [LANES-1:0] exec_q,
  output logic [LANES-1:0] vcc_q
);
  logic [LANES-1:0] exec_d, vcc_d;
  logic             exec_en, vcc_en;
  logic [LANES-1:0] sreg_q [NSREG];
  logic [LANES-1:0] sreg_rd;

  assign sreg_rd = sreg_q[sel_i];
  assign exec_en = ctrl_i.and_vcc | ctrl_i.inv | ctrl_i.and_sreg | ctrl_i.restore;
  assign vcc_en  = ctrl_i.vcmp;

  always_comb begin
    exec_d = exec_q;
    vcc_d  = vcc_q;
    if (ctrl_i.vcmp)     vcc_d  = (vcc_q & ~exec_q) | (cmp_i & exec_q);
    if (ctrl_i.and_vcc)  exec_d = exec_q & vcc_q;
    if (ctrl_i.inv)      exec_d = ~exec_q;
    if (ctrl_i.and_sreg) exec_d = exec_q & sreg_rd;
    if (ctrl_i.restore)  exec_d = sreg_rd;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      exec_q <= '1;
      vcc_q  <= '0;
    end else begin
      if (exec_en) exec_q <= exec_d;
      if (vcc_en)  vcc_q  <= vcc_d;
    end
  end

  for (genvar g = 0; g < NSREG; g++) begin : g_sreg
    logic wr_en;
    assign wr_en = ctrl_i.save && (sel_i == SEL_W'(g));
    always_ff @(posedge clk or negedge rst_ni) begin
      if (!rst_ni)    sreg_q[g] <= '0;
      else if (wr_en) sreg_q[g] <= exec_q;
    end
  end

  // R2
  vcmp_inactive_hold_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    ctrl_i.vcmp |=> ((vcc_q & ~$past(exec_q)) == ($past(vcc_q) & ~$past(exec_q))));

  // R5
  exec_invert_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    ctrl_i.inv |=> (exec_q == ~$past(exec_q)));

  // R3
  exec_restore_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    ctrl_i.restore |=> (exec_q == $past(sreg_rd)));

  // R10
  idle_masks_stable_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (ctrl_i == '0) |=> ($stable(exec_q) && $stable(vcc_q)));
endmodule

// File: rtl/lmc_seq.sv
module lmc_seq
  import lmc_pkg::*;
#(
  parameter int LANES = 8,
  parameter int PC_W  = 16
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  ctrl_t            ctrl_i,
  input  logic [LANES-1:0] exec_i,
  input  logic [LANES-1:0] vcc_i,
  input  logic [PC_W-1:0]  tgt_i,
  output logic [PC_W-1:0]  pc_q,
  output logic             taken_q
);
  logic            take;
  logic [PC_W-1:0] pc_d;

  always_comb begin
    take = (ctrl_i.br_cz && (vcc_i == '0)) || (ctrl_i.br_ez && (exec_i == '0));
    pc_d = take ? tgt_i : pc_q + PC_W'(1);
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q    <= '0;
      taken_q <= 1'b0;
    end else begin
      taken_q <= take;
      if (ctrl_i.adv) pc_q <= pc_d;
    end
  end

  // R9
  pc_step_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (ctrl_i.adv && !taken_q && !ctrl_i.br_cz && !ctrl_i.br_ez) |=> (pc_q == $past(pc_q) + PC_W'(1)));

  // R8
  execz_branch_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (ctrl_i.br_ez && exec_i == '0) |=> (taken_q && pc_q == $past(tgt_i)));

  // R7
  vccz_fall_through_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (ctrl_i.br_cz && vcc_i != '0) |=> !taken_q);

  // R10
  idle_no_branch_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    !ctrl_i.adv |=> (!taken_q && $stable(pc_q)));
endmodule

// File: rtl/lane_mask_ctrl.sv
module lane_mask_ctrl
  import lmc_pkg::*;
#(
  parameter int LANES = 8,
  parameter int NSREG = 4,
  parameter int PC_W  = 16,
  localparam int SEL_W = $clog2(NSREG)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             instr_valid,
  input  logic [OP_W-1:0]  opcode,
  input  logic [SEL_W-1:0] sreg_sel,
  input  logic [LANES-1:0] lane_cmp,
  input  logic [PC_W-1:0]  br_target,
  output logic [LANES-1:0] exec_mask,
  output logic             br_taken,
  output logic [PC_W-1:0]  pc_next
);
  logic [1:0]       rst_sync;
  logic             rst_i;
  ctrl_t            ctrl;
  logic [LANES-1:0] vcc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_i = rst_sync[1];

  lmc_decode u_dec (
    .valid_i (instr_valid),
    .op_i    (opcode),
    .ctrl_o  (ctrl)
  );

  lmc_mask_regs #(.LANES(LANES), .NSREG(NSREG)) u_regs (
    .clk    (clk),
    .rst_ni (rst_i),
    .ctrl_i (ctrl),
    .sel_i  (sreg_sel),
    .cmp_i  (lane_cmp),
    .exec_q (exec_mask),
    .vcc_q  (vcc)
  );

  lmc_seq #(.LANES(LANES), .PC_W(PC_W)) u_seq (
    .clk     (clk),
    .rst_ni  (rst_i),
    .ctrl_i  (ctrl),
    .exec_i  (exec_mask),
    .vcc_i   (vcc),
    .tgt_i   (br_target),
    .pc_q    (pc_next),
    .taken_q (br_taken)
  );
endmodule

// File: tb/lane_mask_ctrl_test.sv
module lane_mask_ctrl_test;
  typedef struct {
    logic [7:0]  exec;
    logic        taken;
    logic [15:0] pc;
    string       req;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        instr_valid = 1'b0;
  logic [3:0]  opcode = '0;
  logic [1:0]  sreg_sel = '0;
  logic [7:0]  lane_cmp = '0;
  logic [15:0] br_target = '0;
  logic [7:0]  exec_mask;
  logic        br_taken;
  logic [15:0] pc_next;

  int checks = 0;
  int bad = 0;
  bit done = 0;
  exp_t q[$];

  logic [7:0]  m_exec = 8'hFF;
  logic [7:0]  m_vcc  = 8'h00;
  logic [7:0]  m_sreg [4] = '{default: 8'h00};
  logic [15:0] m_pc   = 16'h0;

  always #5 clk = ~clk;

  lane_mask_ctrl uut (
    .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .opcode(opcode),
    .sreg_sel(sreg_sel), .lane_cmp(lane_cmp), .br_target(br_target),
    .exec_mask(exec_mask), .br_taken(br_taken), .pc_next(pc_next)
  );

  task automatic check(input string req, input logic [7:0] ex, input logic tk, input logic [15:0] pc);
    checks++;
    if (exec_mask !== ex || br_taken !== tk || pc_next !== pc) begin
      bad++;
      $display("FAIL %s: got exec=%h taken=%b pc=%h, want exec=%h taken=%b pc=%h",
               req, exec_mask, br_taken, pc_next, ex, tk, pc);
    end
  endtask

  task automatic issue(input logic v, input logic [3:0] op, input logic [1:0] s,
                       input logic [7:0] c, input logic [15:0] t, input string req);
    exp_t e;
    logic tk;
    @(negedge clk);
    instr_valid = v; opcode = op; sreg_sel = s; lane_cmp = c; br_target = t;
    tk = 1'b0;
    if (v) begin
      case (op)
        4'd1: m_vcc = (m_vcc & ~m_exec) | (c & m_exec);
        4'd2: m_sreg[s] = m_exec;
        4'd3: m_exec = m_exec & m_vcc;
        4'd4: m_exec = ~m_exec;
        4'd5: m_exec = m_exec & m_sreg[s];
        4'd6: m_exec = m_sreg[s];
        4'd7: tk = (m_vcc == 8'h00);
        4'd8: tk = (m_exec == 8'h00);
        default: ;
      endcase
      m_pc = tk ? t : m_pc + 16'd1;
    end
    e.exec = m_exec; e.taken = tk; e.pc = m_pc; e.req = req;
    q.push_back(e);
  endtask

  always @(posedge clk) begin : monitor
    exp_t e;
    #1;
    if (q.size() > 0) begin
      e = q.pop_front();
      check(e.req, e.exec, e.taken, e.pc);
    end
  end

  initial begin : watchdog
    #(200000 * 10);
    if (!done) begin
      done = 1;
      bad++;
      $display("FAIL watchdog: got running, want finished");
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 reset state", 8'hFF, 1'b0, 16'h0000);
    // R1: condition mask is zero after reset, so this branch is taken
    issue(1, 4'd7, 0, 8'h00, 16'h0040, "R1 vcc zero after reset");
    // R12 scenario: compare true in lanes 0, 2, 5
    issue(1, 4'd1, 0, 8'h25, 16'h0000, "R2 compare full mask");
    issue(1, 4'd2, 0, 8'h00, 16'h0000, "R3 save exec");
    issue(1, 4'd3, 0, 8'h00, 16'h0000, "R4 and with vcc");
    issue(1, 4'd7, 0, 8'h00, 16'h0100, "R7 vccz not taken");
    issue(1, 4'd4, 0, 8'h00, 16'h0000, "R5 invert exec");
    issue(1, 4'd5, 0, 8'h00, 16'h0000, "R12 else mask 0xDA (R6)");
    issue(1, 4'd8, 0, 8'h00, 16'h0200, "R11 execz right after update, not taken");
    issue(1, 4'd6, 0, 8'h00, 16'h0000, "R3 restore exec");
    // all lanes fail the compare
    issue(1, 4'd1, 0, 8'h00, 16'h0000, "R2 compare all false");
    issue(1, 4'd7, 0, 8'h00, 16'h0300, "R7 vccz taken");
    issue(1, 4'd3, 0, 8'h00, 16'h0000, "R4 and gives zero");
    issue(1, 4'd8, 0, 8'h00, 16'h0400, "R8 execz taken");
    issue(1, 4'd1, 0, 8'hFF, 16'h0000, "R2 compare with no live lane");
    issue(1, 4'd7, 0, 8'h00, 16'h0500, "R2 vcc untouched, branch taken");
    issue(1, 4'd6, 0, 8'h00, 16'h0000, "R3 restore all ones");
    // partial mask held in another scalar register
    issue(1, 4'd1, 0, 8'hF0, 16'h0000, "R2 compare upper half");
    issue(1, 4'd3, 0, 8'h00, 16'h0000, "R4 exec upper half");
    issue(1, 4'd2, 2, 8'h00, 16'h0000, "R3 save to register 2");
    issue(1, 4'd1, 0, 8'h3C, 16'h0000, "R2 partial merge");
    issue(1, 4'd3, 0, 8'h00, 16'h0000, "R4 merged vcc and exec");
    issue(1, 4'd4, 0, 8'h00, 16'h0000, "R5 invert partial");
    issue(1, 4'd5, 2, 8'h00, 16'h0000, "R6 and with register 2");
    issue(1, 4'd8, 0, 8'h00, 16'h0600, "R8 execz not taken");
    issue(1, 4'd5, 0, 8'h00, 16'h0000, "R6 and with register 0");
    // idle and unused opcodes
    issue(0, 4'd4, 0, 8'hFF, 16'h0700, "R10 valid low ignored");
    issue(0, 4'd7, 0, 8'h00, 16'h0700, "R10 valid low branch ignored");
    issue(1, 4'd0, 0, 8'h00, 16'h0000, "R9 nop advances");
    issue(1, 4'd12, 1, 8'hFF, 16'h0800, "R10 unused opcode only advances");
    issue(1, 4'd6, 2, 8'h00, 16'h0000, "R3 restore register 2");
    issue(1, 4'd8, 0, 8'h00, 16'h0900, "R9 branch not taken advances");
    issue(0, 4'd0, 0, 8'h00, 16'h0000, "R10 idle");
    repeat (3) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end
endmodule